// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Control

This block compares two divided clocks in a frequency synthesizer loop. One is the divided reference and the other is the divided oscillator. From their rising edges it produces pump-up and pump-down commands. A three-state detector with an up flop and a down flop handles phase errors of up to plus or minus one full period, and it also steers the loop toward the right frequency. When both flops are set, both clear one clock later. As a result, even a locked loop emits one-cycle pulses on both commands at each comparison.

The loop controller configures the block through a set of mode inputs:
- a sign bit that swaps the meaning of up and down;
- a 2-bit pump current code, passed through to the analog current sources;
- a pump test mode that forces a constant source, a constant sink or high impedance;
- a synthesizer enable. When the enable is low, the pump is parked at high impedance and the lock state is discarded.

A single observation pin carries one of five things: the lock indication, a constant low, serial readback data, the raw reference level or the raw divided-oscillator level. Lock is declared after a programmable number of consecutive comparisons in which the lead between the two edges stays within a small window. The first comparison that falls outside the window drops the lock.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: A rising edge on the leading input sets its detector flop one clock after the edge is sampled. The flop stays set until one clock after the lagging input's flop is set, and then both clear. The pump command of the leading input stays high for the lead in clocks plus one. The lagging command is high for one clock.
- R2: When both inputs rise in the same clock, each pump command gives a single one-clock pulse, and the two pulses coincide.
- R3: With pump_sign = 0, up_o follows the reference-side flop and dn_o follows the oscillator-side flop. With pump_sign = 1, the two are swapped.
- R4: cur_o equals cur_sel one clock later. The codes are 0 = lowest current, 1 and 2 the middle currents, and 3 = highest current.
- R5: pump_mode 0 selects normal operation. Code 1 forces up_o=1, dn_o=0, hiz_o=0. Code 2 forces up_o=0, dn_o=1, hiz_o=0. Code 3 forces up_o=0, dn_o=0, hiz_o=1. Each takes effect one clock after it is applied.
- R6: Lock is declared after LOCK_CNT (default 4) consecutive comparisons whose lead is at most LOCK_WIN (default 1) clocks. After 3 such comparisons it is still low.
- R7: The first comparison with a lead larger than LOCK_WIN clears lock and restarts the count.
- R8: ld_o is selected by ld_sel[2:1] and ld_sel[0]:
  - ld_sel = 000 or 001 gives the lock flag;
  - 010 or 011 gives a constant 0;
  - 100 or 101 gives rdbk_in;
  - 110 gives ref_in;
  - 111 gives div_in.
  The selected value appears on ld_o one clock later.
- R9: While synth_en = 0, hiz_o=1, up_o=0 and dn_o=0, and lock is held low.
- R10: After reset, up_o=0, dn_o=0, hiz_o=1, cur_o=0 and ld_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| synth_en | input | 1 | Synthesizer enable |
| ref_in | input | 1 | Divided reference level |
| div_in | input | 1 | Divided oscillator level |
| pump_sign | input | 1 | Swap up/down sense |
| pump_mode | input | 2 | Normal / source / sink / high-Z |
| cur_sel | input | 2 | Pump current code |
| ld_sel | input | 3 | Observation pin select |
| rdbk_in | input | 1 | Serial readback data |
| up_o | output | 1 | Pump source command |
| dn_o | output | 1 | Pump sink command |
| hiz_o | output | 1 | Pump high-impedance command |
| cur_o | output | 2 | Registered current code |
| ld_o | output | 1 | Observation pin |

## Verification
The clear-after-overlap property assumes that neither input rises in the same clock in which the detector clears. The stimulus meets this by holding each input high until both have been seen, and by idling several clocks between comparisons. The other properties assume only that the mode inputs are held steady for at least one clock, and the bench changes mode inputs only between comparisons.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_SOURCE = 2'd1,
    PM_SINK   = 2'd2,
    PM_HIZ    = 2'd3
  } pump_mode_e;

  localparam logic [1:0] LDG_LOCK = 2'b00;
  localparam logic [1:0] LDG_LOW  = 2'b01;
  localparam logic [1:0] LDG_RDBK = 2'b10;
  localparam logic [1:0] LDG_RAW  = 2'b11;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ref_in,
  input  logic div_in,
  output logic up_st,
  output logic dn_st
);
  logic ref_q, div_q;
  logic ref_rise, div_rise, both;

  assign ref_rise = ref_in & ~ref_q;
  assign div_rise = div_in & ~div_q;
  assign both     = up_st & dn_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
      div_q <= div_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      up_st <= 1'b0;
      dn_st <= 1'b0;
    end else if (both) begin
      up_st <= ref_rise;
      dn_st <= div_rise;
    end else begin
      up_st <= up_st | ref_rise;
      dn_st <= dn_st | div_rise;
    end
  end

  // R1: overlap is removed one clock after both flops are set
  a_r1_clear_after_overlap: assert property (@(posedge clk) disable iff (rst)
    (up_st && dn_st && !ref_rise && !div_rise) |=> (!up_st && !dn_st));
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int LOCK_CNT = 4,
  parameter int LOCK_WIN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic up_st,
  input  logic dn_st,
  output logic locked
);
  localparam int LW = $clog2(LOCK_WIN + 2);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [LW-1:0] WIN_V  = LW'(LOCK_WIN);
  localparam logic [LW-1:0] LEAD_MAX = LW'(LOCK_WIN + 1);
  localparam logic [GW-1:0] CNT_LAST = GW'(LOCK_CNT - 1);
  localparam logic [GW-1:0] CNT_MAX  = GW'(LOCK_CNT);

  logic [LW-1:0] lead_cnt;
  logic [GW-1:0] good_cnt;
  logic both, in_win;

  assign both   = up_st & dn_st;
  assign in_win = (lead_cnt <= WIN_V);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lead_cnt <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (both) begin
      lead_cnt <= '0;
      if (in_win) begin
        if (good_cnt >= CNT_LAST) locked <= 1'b1;
        if (good_cnt != CNT_MAX) good_cnt <= good_cnt + 1'b1;
      end else begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end
    end else if ((up_st ^ dn_st) && lead_cnt != LEAD_MAX) begin
      lead_cnt <= lead_cnt + 1'b1;
    end
  end

  // R7: an out-of-window comparison drops lock
  a_r7_violation_unlocks: assert property (@(posedge clk) disable iff (rst)
    (both && !in_win) |=> !locked);
  // R6: lock only rises on a comparison
  a_r6_rise_on_compare: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(both));
endmodule

// File: rtl/pfd_pump_out.sv
module pfd_pump_out
  import pfd_cp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       sign,
  input  logic [1:0] mode,
  input  logic [1:0] cur_sel,
  input  logic       up_st,
  input  logic       dn_st,
  output logic       up_o,
  output logic       dn_o,
  output logic       hiz_o,
  output logic [1:0] cur_o
);
  pump_mode_e pm;
  logic up_n, dn_n, hz_n;

  assign pm = pump_mode_e'(mode);

  always_comb begin
    up_n = 1'b0;
    dn_n = 1'b0;
    hz_n = 1'b0;
    if (!en) begin
      hz_n = 1'b1;
    end else begin
      unique case (pm)
        PM_NORMAL: begin
          up_n = sign ? dn_st : up_st;
          dn_n = sign ? up_st : dn_st;
        end
        PM_SOURCE: up_n = 1'b1;
        PM_SINK:   dn_n = 1'b1;
        default:   hz_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
      hiz_o <= 1'b1;
      cur_o <= 2'd0;
    end else begin
      up_o  <= up_n;
      dn_o  <= dn_n;
      hiz_o <= hz_n;
      cur_o <= cur_sel;
    end
  end

  // R9: disabled synthesizer parks the pump
  a_r9_disabled_hiz: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hiz_o && !up_o && !dn_o));
  // R5: forced source mode
  a_r5_force_source: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'd1) |=> (up_o && !dn_o && !hiz_o));
  // R5: high impedance never coexists with a drive command
  a_r5_hiz_quiet: assert property (@(posedge clk) disable iff (rst)
    hiz_o |-> (!up_o && !dn_o));
  // R4: current code follows its select
  a_r4_cur_follow: assert property (@(posedge clk) disable iff (rst)
    $stable(cur_sel) |=> (cur_o == $past(cur_sel)));
endmodule

// File: rtl/pfd_ld_mux.sv
module pfd_ld_mux
  import pfd_cp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       locked,
  input  logic       rdbk_in,
  input  logic       ref_in,
  input  logic       div_in,
  output logic       ld_o
);
  logic ld_n;

  always_comb begin
    unique case (sel[2:1])
      LDG_LOCK: ld_n = locked;
      LDG_LOW:  ld_n = 1'b0;
      LDG_RDBK: ld_n = rdbk_in;
      default:  ld_n = sel[0] ? div_in : ref_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ld_o <= 1'b0;
    else     ld_o <= ld_n;
  end

  // R8: the low selection holds the pin low
  a_r8_low_select: assert property (@(posedge clk) disable iff (rst)
    (sel[2:1] == LDG_LOW) |=> !ld_o);
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl #(
  parameter int LOCK_CNT = 4,
  parameter int LOCK_WIN = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       synth_en,
  input  logic       ref_in,
  input  logic       div_in,
  input  logic       pump_sign,
  input  logic [1:0] pump_mode,
  input  logic [1:0] cur_sel,
  input  logic [2:0] ld_sel,
  input  logic       rdbk_in,
  output logic       up_o,
  output logic       dn_o,
  output logic       hiz_o,
  output logic [1:0] cur_o,
  output logic       ld_o
);
  logic up_st, dn_st, locked;

  pfd_core u_core (
    .clk(clk), .rst(rst), .clr(~synth_en),
    .ref_in(ref_in), .div_in(div_in),
    .up_st(up_st), .dn_st(dn_st)
  );

  pfd_lock_det #(.LOCK_CNT(LOCK_CNT), .LOCK_WIN(LOCK_WIN)) u_lock (
    .clk(clk), .rst(rst), .clr(~synth_en),
    .up_st(up_st), .dn_st(dn_st), .locked(locked)
  );

  pfd_pump_out u_pump (
    .clk(clk), .rst(rst), .en(synth_en), .sign(pump_sign),
    .mode(pump_mode), .cur_sel(cur_sel),
    .up_st(up_st), .dn_st(dn_st),
    .up_o(up_o), .dn_o(dn_o), .hiz_o(hiz_o), .cur_o(cur_o)
  );

  pfd_ld_mux u_ld (
    .clk(clk), .rst(rst), .sel(ld_sel), .locked(locked),
    .rdbk_in(rdbk_in), .ref_in(ref_in), .div_in(div_in), .ld_o(ld_o)
  );

  // R9: lock is never reported while disabled
  a_r9_no_lock_disabled: assert property (@(posedge clk) disable iff (rst)
    !synth_en |=> !locked);
endmodule

// File: tb/tb_pfd_cp_ctrl.sv
`timescale 1ns/1ps
module tb_pfd_cp_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic synth_en = 1'b1, ref_in = 1'b0, div_in = 1'b0, pump_sign = 1'b0, rdbk_in = 1'b0;
  logic [1:0] pump_mode = 2'd0, cur_sel = 2'd0;
  logic [2:0] ld_sel = 3'b000;
  logic up_o, dn_o, hiz_o, ld_o;
  logic [1:0] cur_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pfd_cp_ctrl dut (
    .clk(clk), .rst(rst), .synth_en(synth_en), .ref_in(ref_in), .div_in(div_in),
    .pump_sign(pump_sign), .pump_mode(pump_mode), .cur_sel(cur_sel), .ld_sel(ld_sel),
    .rdbk_in(rdbk_in), .up_o(up_o), .dn_o(dn_o), .hiz_o(hiz_o), .cur_o(cur_o), .ld_o(ld_o)
  );

  // fields: ref_first[12], lead[11:9], sign[8], up count[7:4], down count[3:0]
  localparam logic [12:0] VEC [7] = '{
    {1'b1, 3'd3, 1'b0, 4'd4, 4'd1},
    {1'b0, 3'd3, 1'b0, 4'd1, 4'd4},
    {1'b1, 3'd3, 1'b1, 4'd1, 4'd4},
    {1'b0, 3'd2, 1'b1, 4'd3, 4'd1},
    {1'b1, 3'd0, 1'b0, 4'd1, 4'd1},
    {1'b0, 3'd5, 1'b0, 4'd1, 4'd6},
    {1'b1, 3'd1, 1'b1, 4'd1, 4'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one comparison; counts clocks with up_o and dn_o high
  task automatic compare(input bit rf, input int k, output int nu, output int nd);
    nu = 0;
    nd = 0;
    @(negedge clk);
    if (rf || k == 0) ref_in = 1'b1;
    if (!rf || k == 0) div_in = 1'b1;
    for (int c = 1; c <= k + 8; c++) begin
      @(negedge clk);
      nu += int'(up_o);
      nd += int'(dn_o);
      if (c == k) begin
        ref_in = 1'b1;
        div_in = 1'b1;
      end
      if (c == k + 1) begin
        ref_in = 1'b0;
        div_in = 1'b0;
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nu, nd;
    idle(3);
    // R10 reset state
    check("R10 up", int'(up_o), 0);
    check("R10 dn", int'(dn_o), 0);
    check("R10 hiz", int'(hiz_o), 1);
    check("R10 cur", int'(cur_o), 0);
    check("R10 ld", int'(ld_o), 0);
    rst = 1'b0;
    idle(3);

    // R1 R2 R3 vector walk
    foreach (VEC[i]) begin
      pump_sign = VEC[i][8];
      idle(2);
      compare(VEC[i][12], int'(VEC[i][11:9]), nu, nd);
      check("R1/R3 up width", nu, int'(VEC[i][7:4]));
      check("R1/R3 dn width", nd, int'(VEC[i][3:0]));
    end
    pump_sign = 1'b0;

    // R2 aligned edges: coincident single pulses
    @(negedge clk); ref_in = 1'b1; div_in = 1'b1;
    idle(2);
    check("R2 up aligned", int'(up_o), 1);
    check("R2 dn aligned", int'(dn_o), 1);
    idle(1);
    check("R2 up cleared", int'(up_o), 0);
    ref_in = 1'b0; div_in = 1'b0;
    idle(4);

    // R6 R7 lock detection from a clean state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(2);
    for (int j = 0; j < 3; j++) compare(1'b1, 1, nu, nd);
    check("R6 not yet locked", int'(ld_o), 0);
    compare(1'b0, 1, nu, nd);
    check("R6 locked after 4", int'(ld_o), 1);
    compare(1'b1, 0, nu, nd);
    check("R6 stays locked", int'(ld_o), 1);

    // R8 mux while locked
    ld_sel = 3'b011; idle(2);
    check("R8 low select", int'(ld_o), 0);
    ld_sel = 3'b100; rdbk_in = 1'b1; idle(2);
    check("R8 readback 1", int'(ld_o), 1);
    rdbk_in = 1'b0; idle(2);
    check("R8 readback 0", int'(ld_o), 0);
    ld_sel = 3'b000; idle(2);
    check("R8 lock select", int'(ld_o), 1);

    compare(1'b1, 2, nu, nd);
    check("R7 unlock on violation", int'(ld_o), 0);
    for (int j = 0; j < 3; j++) compare(1'b0, 0, nu, nd);
    check("R7 count restarted", int'(ld_o), 0);
    compare(1'b0, 0, nu, nd);
    check("R7 relock", int'(ld_o), 1);

    // R8 raw level selections
    ld_sel = 3'b110; ref_in = 1'b1; idle(2);
    check("R8 ref level", int'(ld_o), 1);
    ld_sel = 3'b111; idle(2);
    check("R8 div level low", int'(ld_o), 0);
    div_in = 1'b1; idle(2);
    check("R8 div level high", int'(ld_o), 1);
    ref_in = 1'b0; div_in = 1'b0; idle(4);
    ld_sel = 3'b000;

    // R4 current code
    cur_sel = 2'd2; idle(2);
    check("R4 cur 2", int'(cur_o), 2);
    cur_sel = 2'd3; idle(2);
    check("R4 cur 3", int'(cur_o), 3);

    // R5 forced pump modes
    pump_mode = 2'd1; idle(2);
    check("R5 source up", int'(up_o), 1);
    check("R5 source dn", int'(dn_o), 0);
    pump_mode = 2'd2; idle(2);
    check("R5 sink dn", int'(dn_o), 1);
    check("R5 sink up", int'(up_o), 0);
    pump_mode = 2'd3; idle(2);
    check("R5 hiz", int'(hiz_o), 1);
    check("R5 hiz up", int'(up_o), 0);
    pump_mode = 2'd0; idle(2);
    check("R5 normal hiz off", int'(hiz_o), 0);

    // R9 disable
    pump_mode = 2'd1;
    synth_en = 1'b0; idle(2);
    check("R9 hiz", int'(hiz_o), 1);
    check("R9 up", int'(up_o), 0);
    check("R9 lock low", int'(ld_o), 0);
    synth_en = 1'b1; idle(2);
    check("R9 source resumes", int'(up_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule